// File: doc/BRIEF.md
# Flash Sector Map and Boot Protection Guard

This block sits in front of the program and erase engines of an 18-bit byte-addressed flash array. It assigns each incoming address to one of five sectors, decides whether a program or erase request may go ahead, and produces the set of sectors that an accepted erase must clear. It also holds the sticky boot-lock bit that guards the boot sector. The lock bit can only be set, and only a reset clears it.

A build-time parameter chooses the layout. In the bottom-boot layout the small sectors sit at the low end of the address space. In the top-boot layout the same sectors are mirrored to the high end. An override input lifts the boot lock for as long as it is held. While it is held, requests to the boot sector are handled as if the lock were clear.

A request is sampled on one clock edge. Its decision shows up on the registered outputs for exactly one cycle after that edge. An identification read port returns the lock state at a fixed location inside the boot sector.

Top module: `sector_guard`

## Requirements
- R1: With TOP_BOOT=0, sector_o takes these codes: 0 (boot) for 00000–03FFF, 1 for 04000–05FFF, 2 for 06000–07FFF, 3 for 08000–1FFFF and 4 for 20000–3FFFF.
- R2: With TOP_BOOT=1, sector_o takes these codes: 0 (boot) for 3C000–3FFFF, 1 for 3A000–3BFFF, 2 for 38000–39FFF, 3 for 20000–37FFF and 4 for 00000–1FFFF.
- R3: If the lock is set and override_i is low, a program (req_kind_i=0) or sector erase (req_kind_i=1) whose address falls in sector 0 raises reject_o for one cycle. It raises no grant_o and drives erase_mask_o to zero.
- R4: Every other program request raises grant_o and leaves erase_mask_o at zero.
- R5: An accepted sector erase raises grant_o together with an erase_mask_o in which only bit n is set, where n is the sector code of the address.
- R6: A chip erase (req_kind_i=2) is always granted. Its mask is 5'b11111 when the lock is clear or overridden, and 5'b11110 when the lock is in force, so the boot sector is kept.
- R7: While override_i is high in the request cycle, the lock has no effect. The next request made with override_i low is refused again.
- R8: A lock-enable request (req_kind_i=3) is granted and sets lock_o from the following cycle on. No request clears lock_o; only rst_n low clears it.
- R9: id_rdata_o equals {7'b0, lock_o} when id_addr_i is the boot sector base plus 2 (00002 for bottom boot, 3C002 for top boot). At every other address it is 8'h00.
- R10: grant_o and reject_o are never high together, and both are low in any cycle that follows a cycle with no request.
- R11: After a synchronous reset, grant_o, reject_o, erase_mask_o, sector_o and lock_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the lock |
| req_valid_i | input | 1 | A request is present this cycle |
| req_kind_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 lock enable |
| req_addr_i | input | 18 | Byte address of the request |
| override_i | input | 1 | Lifts the boot lock for this request |
| id_addr_i | input | 18 | Identification read address |
| grant_o | output | 1 | Request accepted (one-cycle pulse) |
| reject_o | output | 1 | Request refused (one-cycle pulse) |
| erase_mask_o | output | 5 | Sectors to clear, bit n for sector code n |
| sector_o | output | 3 | Sector code of the last sampled address |
| lock_o | output | 1 | Boot lock state |
| id_rdata_o | output | 8 | Identification read data |

## Verification
The hardest state to reach is a locked part that is still in the same run. The lock is one-way, so every unlocked case has to be exercised first. The stimulus therefore sweeps and probes all sector boundaries with the lock clear, enables the lock, and repeats the same sweeps with and without override. Only a final reset shows that the lock clears. Both layouts are instantiated side by side on shared inputs, so each request checks the mirrored decode and the plain decode in the same cycle.

// File: rtl/sg_pkg.sv
// Shared types for the sector guard: request kinds and sector codes.
package sg_pkg;
    localparam int NUM_SECT = 5;

    typedef enum logic [1:0] {
        REQ_PROG   = 2'b00,
        REQ_SERASE = 2'b01,
        REQ_CERASE = 2'b10,
        REQ_LOCK   = 2'b11
    } req_kind_t;

    typedef enum logic [2:0] {
        SEC_BOOT  = 3'd0,
        SEC_PAR1  = 3'd1,
        SEC_PAR2  = 3'd2,
        SEC_MAIN1 = 3'd3,
        SEC_MAIN2 = 3'd4
    } sector_t;
endpackage

// File: rtl/sg_decode.sv
// Address to sector decoder.
// Assumes: boot = 1/16 of the space, each parameter sector = 1/32,
// the large main sector = upper half of the normalized space.
// The top-boot layout is the bottom-boot layout mirrored, so the
// address is complemented before the same compare chain is applied.
module sg_decode
    import sg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sector_t           sec_o
);
    localparam int BOOT_SZ = 1 << (ADDR_W - 4);
    localparam int PAR_SZ  = 1 << (ADDR_W - 5);
    localparam int HALF    = 1 << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] LIM_BOOT = ADDR_W'(BOOT_SZ);
    localparam logic [ADDR_W-1:0] LIM_PAR1 = ADDR_W'(BOOT_SZ + PAR_SZ);
    localparam logic [ADDR_W-1:0] LIM_PAR2 = ADDR_W'(BOOT_SZ + 2 * PAR_SZ);
    localparam logic [ADDR_W-1:0] LIM_MAIN = ADDR_W'(HALF);

    logic [ADDR_W-1:0] norm;

    // Pick the layout variant: mirror the address for top boot.
    generate
        if (TOP_BOOT) begin : g_top
            assign norm = ~addr_i;
        end else begin : g_bottom
            assign norm = addr_i;
        end
    endgenerate

    // Compare the normalized address against the ascending limits.
    always_comb begin
        if (norm < LIM_BOOT)      sec_o = SEC_BOOT;
        else if (norm < LIM_PAR1) sec_o = SEC_PAR1;
        else if (norm < LIM_PAR2) sec_o = SEC_PAR2;
        else if (norm < LIM_MAIN) sec_o = SEC_MAIN1;
        else                      sec_o = SEC_MAIN2;
    end
endmodule

// File: rtl/sg_lock.sv
// Sticky boot-lock bit.
// Assumes: set_i is a single-cycle command strobe; only reset clears.
module sg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic lock_o
);
    // Hold the lock once set; clear only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_o <= 1'b0;
        else if (set_i) lock_o <= 1'b1;
    end

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);
    a_r8_lock_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(set_i));
endmodule

// File: rtl/sg_policy.sv
// Decision logic: grant or refuse a request and build the erase mask.
// Assumes: sec_i is the decoded sector of the request address and
// lock_i the current lock state; purely combinational.
module sg_policy
    import sg_pkg::*;
(
    input  logic                valid_i,
    input  req_kind_t           kind_i,
    input  sector_t             sec_i,
    input  logic                lock_i,
    input  logic                override_i,
    output logic                grant_d,
    output logic                reject_d,
    output logic [NUM_SECT-1:0] mask_d,
    output logic                set_lock_o
);
    logic                lock_eff;
    logic                hits_boot;
    logic [NUM_SECT-1:0] sect_onehot;
    logic [NUM_SECT-1:0] chip_mask;

    assign lock_eff  = lock_i & ~override_i;
    assign hits_boot = (sec_i == SEC_BOOT);

    // One mask bit per sector; the boot bit of a chip erase follows the lock.
    generate
        for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
            assign sect_onehot[g] = (sec_i == sector_t'(g));
            if (g == 0) begin : g_boot
                assign chip_mask[g] = ~lock_eff;
            end else begin : g_other
                assign chip_mask[g] = 1'b1;
            end
        end
    endgenerate

    // Decide the outcome of the request present this cycle.
    always_comb begin
        grant_d    = 1'b0;
        reject_d   = 1'b0;
        mask_d     = '0;
        set_lock_o = 1'b0;
        if (valid_i) begin
            case (kind_i)
                REQ_PROG: begin
                    if (lock_eff && hits_boot) reject_d = 1'b1;
                    else                       grant_d  = 1'b1;
                end
                REQ_SERASE: begin
                    if (lock_eff && hits_boot) begin
                        reject_d = 1'b1;
                    end else begin
                        grant_d = 1'b1;
                        mask_d  = sect_onehot;
                    end
                end
                REQ_CERASE: begin
                    grant_d = 1'b1;
                    mask_d  = chip_mask;
                end
                default: begin
                    grant_d    = 1'b1;
                    set_lock_o = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sector_guard.sv
// Sector map and boot protection guard (top).
// Samples one request per clock, answers with one-cycle grant or reject
// pulses and an erase mask on the following cycle, keeps the lock bit
// and serves the lock-status identification read.
// Assumes: synchronous active-low reset; ADDR_W >= 6.
module sector_guard
    import sg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [1:0]          req_kind_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                override_i,
    input  logic [ADDR_W-1:0]   id_addr_i,
    output logic                grant_o,
    output logic                reject_o,
    output logic [NUM_SECT-1:0] erase_mask_o,
    output logic [2:0]          sector_o,
    output logic                lock_o,
    output logic [DATA_W-1:0]   id_rdata_o
);
    localparam int BOOT_BASE = TOP_BOOT ? ((1 << ADDR_W) - (1 << (ADDR_W - 4))) : 0;
    localparam logic [ADDR_W-1:0] ID_LOCK_ADDR = ADDR_W'(BOOT_BASE + 2);

    sector_t             sec;
    logic                grant_d;
    logic                reject_d;
    logic [NUM_SECT-1:0] mask_d;
    logic                set_lock;
    logic                lock_q;

    sg_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_decode (
        .addr_i (req_addr_i),
        .sec_o  (sec)
    );

    sg_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_lock),
        .lock_o (lock_q)
    );

    sg_policy u_policy (
        .valid_i    (req_valid_i),
        .kind_i     (req_kind_t'(req_kind_i)),
        .sec_i      (sec),
        .lock_i     (lock_q),
        .override_i (override_i),
        .grant_d    (grant_d),
        .reject_d   (reject_d),
        .mask_d     (mask_d),
        .set_lock_o (set_lock)
    );

    // Register the decision so each response is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o      <= 1'b0;
            reject_o     <= 1'b0;
            erase_mask_o <= '0;
            sector_o     <= '0;
        end else begin
            grant_o      <= grant_d;
            reject_o     <= reject_d;
            erase_mask_o <= mask_d;
            sector_o     <= sec;
        end
    end

    // Lock status and the identification read of the boot base plus 2.
    assign lock_o     = lock_q;
    assign id_rdata_o = (id_addr_i == ID_LOCK_ADDR) ? {{(DATA_W-1){1'b0}}, lock_q} : '0;

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!grant_o && !reject_o));
    a_r3_reject_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> (sector_o == 3'(SEC_BOOT) && lock_q && erase_mask_o == '0));
    a_r5_mask_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_mask_o != '0) |-> grant_o);
    a_r6_boot_kept_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && erase_mask_o[0]) |-> (!$past(lock_q) || $past(override_i)));
endmodule

// File: tb/sim_sector_guard.sv
`timescale 1ns/1ps
module sim_sector_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [17:0] req_addr;
    logic        ovr;
    logic [17:0] id_addr;

    logic g0, r0, l0, g1, r1, l1;
    logic [4:0] m0, m1;
    logic [2:0] s0, s1;
    logic [7:0] d0, d1;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  done = 1'b0;
    bit  model_lock = 1'b0;

    always #4 clk = ~clk;

    sector_guard #(.TOP_BOOT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
        .req_addr_i(req_addr), .override_i(ovr), .id_addr_i(id_addr),
        .grant_o(g0), .reject_o(r0), .erase_mask_o(m0), .sector_o(s0),
        .lock_o(l0), .id_rdata_o(d0));

    sector_guard #(.TOP_BOOT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
        .req_addr_i(req_addr), .override_i(ovr), .id_addr_i(id_addr),
        .grant_o(g1), .reject_o(r1), .erase_mask_o(m1), .sector_o(s1),
        .lock_o(l1), .id_rdata_o(d1));

    task automatic report();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Sector code from the layout rules (R1 bottom, R2 mirrored top).
    function automatic int exp_sec(logic [17:0] a, bit top);
        logic [17:0] n;
        n = top ? ~a : a;
        if (n < 18'h04000)      return 0;
        else if (n < 18'h06000) return 1;
        else if (n < 18'h08000) return 2;
        else if (n < 18'h20000) return 3;
        else                    return 4;
    endfunction

    // Issue one request to both layouts and check the response.
    task automatic issue(logic [1:0] kind, logic [17:0] addr, bit ov);
        int sec;
        bit lock_eff, er;
        logic [4:0] em;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; ovr = ov;
        @(negedge clk);
        req_valid = 1'b0; ovr = 1'b0;
        case (kind)
            2'd0:    tag = "R3 R4 program";
            2'd1:    tag = "R3 R5 sector erase";
            2'd2:    tag = "R6 chip erase";
            default: tag = "R8 lock enable";
        endcase
        if (ov) tag = {"R7 override ", tag};
        for (int t = 0; t < 2; t++) begin
            sec = exp_sec(addr, t[0]);
            lock_eff = model_lock && !ov;
            er = 1'b0;
            em = 5'h00;
            case (kind)
                2'd0: er = lock_eff && (sec == 0);
                2'd1: begin
                    er = lock_eff && (sec == 0);
                    em = er ? 5'h00 : 5'(1 << sec);
                end
                2'd2: em = lock_eff ? 5'h1E : 5'h1F;
                default: ;
            endcase
            chk(t ? "R2 sector top" : "R1 sector bottom", t ? s1 : s0, sec);
            chk({tag, " grant"},  t ? g1 : g0, !er);
            chk({tag, " reject"}, t ? r1 : r0, er);
            chk({tag, " mask"},   t ? m1 : m0, em);
        end
        if (kind == 2'd3) model_lock = 1'b1;
        chk("R8 lock state", {l1, l0}, {model_lock, model_lock});
        @(negedge clk);
        chk("R10 pulse ends", {g0, r0, g1, r1}, 4'b0000);
    endtask

    // Identification read of the lock status (R9).
    task automatic id_read(logic [17:0] a);
        @(negedge clk);
        id_addr = a;
        #1;
        chk("R9 id bottom", d0, (a == 18'h00002) ? {7'b0, model_lock} : 8'h00);
        chk("R9 id top",    d1, (a == 18'h3C002) ? {7'b0, model_lock} : 8'h00);
    endtask

    // Watchdog: a hung run is reported as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            report();
        end
    end

    initial begin
        logic [17:0] edges [16];
        edges = '{18'h00000, 18'h03FFF, 18'h04000, 18'h05FFF, 18'h06000, 18'h07FFF,
                  18'h08000, 18'h1FFFF, 18'h20000, 18'h37FFF, 18'h38000, 18'h39FFF,
                  18'h3A000, 18'h3BFFF, 18'h3C000, 18'h3FFFF};
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; ovr = 1'b0; id_addr = '0;
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {g0, r0, m0, s0, l0, g1, r1, m1, s1, l1}, 0);
        rst_n = 1'b1;

        // Unlocked sweeps.
        for (int a = 0; a < 'h40000; a += 'h800) issue(2'd0, 18'(a), 1'b0);
        foreach (edges[i]) issue(2'd1, edges[i], 1'b0);
        issue(2'd2, 18'h15555, 1'b0);
        id_read(18'h00002); id_read(18'h3C002); id_read(18'h00003);

        // Enable the lock and repeat under lock.
        issue(2'd3, 18'h05555, 1'b0);
        id_read(18'h00002); id_read(18'h3C002); id_read(18'h3C003); id_read(18'h00000);
        for (int a = 0; a < 'h40000; a += 'h800) issue(2'd0, 18'(a), 1'b0);
        foreach (edges[i]) issue(2'd1, edges[i], 1'b0);
        issue(2'd2, 18'h15555, 1'b0);

        // Override lifts the lock only while held.
        foreach (edges[i]) issue(2'd1, edges[i], 1'b1);
        issue(2'd0, 18'h00010, 1'b1);
        issue(2'd0, 18'h3FFF0, 1'b1);
        issue(2'd2, 18'h15555, 1'b1);
        issue(2'd0, 18'h00010, 1'b0);
        issue(2'd0, 18'h3FFF0, 1'b0);
        issue(2'd2, 18'h15555, 1'b0);

        // Lock stays set; only reset clears it.
        issue(2'd3, 18'h00000, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_lock = 1'b0;
        chk("R8 R11 lock cleared by reset", {l1, l0}, 2'b00);
        issue(2'd1, 18'h00000, 1'b0);
        issue(2'd2, 18'h00000, 1'b0);
        report();
    end
endmodule